// File: doc/BRIEF.md
# UART Interrupt Identification Controller

This block sits inside a UART register file and decides which interrupt the host sees. Five event sources feed it one-cycle set pulses: receiver line status, received data available, character timeout, transmitter holding register empty and modem status. It keeps one pending flag per source. A flag is recorded whether or not its source is enabled. From these flags and a 4-bit enable mask, it holds the currently reported source. It presents that source as an identification byte and drives an interrupt request line.

The surrounding register logic tells the block about host accesses with single-cycle strobes: an enable-register write (with its data), an identification read, a line-status read, a receive-buffer read, a transmit-holding write and a modem-status read. Each strobe retires its own source. When the reported source is retired, the block moves to the next enabled pending source. Retiring a source that is not being reported only drops its flag. The logic that generates the source conditions lives elsewhere.

Top module: `irq_id_ctrl`

## Requirements
- R1: After reset the identification byte is 0xC1, the request line is low, the enable mask is zero and no source is pending.
- R2: The identification byte is 0xC0 ORed with a 4-bit code. The codes are 0x1 when nothing is reported, 0x6 for line status, 0x4 for data available, 0xC for timeout, 0x2 for transmit empty and 0x0 for modem status. The byte is registered, so an event in one cycle shows in the next.
- R3: When the block chooses among enabled pending sources, it takes them in this order: line status, data available, timeout, transmit empty, modem status.
- R4: Enable write data bit 0 enables both data available and timeout. Bit 1 enables transmit empty, bit 2 enables line status and bit 3 enables modem status. Bits 7..4 have no effect.
- R5: A set pulse on a disabled source records its pending flag without changing the byte. Every enable write re-chooses the reported source from the pending flags under the new mask.
- R6: A set pulse on an enabled source of equal or higher priority than the reported one makes it the reported source. A set pulse on an enabled source of lower priority leaves the byte unchanged.
- R7: A line-status read retires line status. A receive-buffer read retires both data available and timeout. A transmit-holding write retires transmit empty. A modem-status read retires modem status.
- R8: An identification read retires transmit empty only when transmit empty is the source reported in that cycle. Otherwise it has no effect.
- R9: Retiring the reported source makes the highest enabled pending source the reported one. If none remains, the byte returns to 0xC1.
- R10: Retiring a source that is not reported clears only its pending flag and leaves the byte unchanged.
- R11: The request line is high exactly when the code is not 0x1.
- R12: A set pulse and a retiring strobe for the same source in the same cycle leave that source pending, and it is not retired.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| ls_set_i | input | 1 | Line-status event pulse |
| rd_set_i | input | 1 | Data-available event pulse |
| to_set_i | input | 1 | Character-timeout event pulse |
| te_set_i | input | 1 | Transmit-empty event pulse |
| ms_set_i | input | 1 | Modem-status event pulse |
| ier_we_i | input | 1 | Enable-register write strobe |
| ier_wdata_i | input | 8 | Enable-register write data |
| iir_rd_i | input | 1 | Identification-register read strobe |
| lsr_rd_i | input | 1 | Line-status-register read strobe |
| rbr_rd_i | input | 1 | Receive-buffer read strobe |
| thr_wr_i | input | 1 | Transmit-holding write strobe |
| msr_rd_i | input | 1 | Modem-status-register read strobe |
| iir_o | output | 8 | Identification byte |
| irq_o | output | 1 | Interrupt request |

## Verification
A pending flag lost or kept wrongly stays hidden while a higher source is reported. It only shows at the ports at the next fall-through or enable write. For that reason the sequences retire the reported source deliberately to expose the flags beneath it, including flags of sources that were retired while not reported. A wrong reported-source register shows in the identification byte one cycle after the event that caused it. The bench checks every step in exactly that cycle, so a stale or early update cannot hide.

// File: rtl/irq_id_pkg.sv
package irq_id_pkg;

  localparam int unsigned NSRC   = 5;
  localparam int unsigned SIDX_W = 3;

  typedef logic [SIDX_W-1:0] sidx_t;

  // Source index doubles as priority: lower index wins
  localparam sidx_t SRC_LS   = 3'd0;
  localparam sidx_t SRC_RD   = 3'd1;
  localparam sidx_t SRC_TO   = 3'd2;
  localparam sidx_t SRC_TE   = 3'd3;
  localparam sidx_t SRC_MS   = 3'd4;
  localparam sidx_t SRC_NONE = 3'd5;

  localparam logic [3:0] CODE_NONE = 4'h1;
  localparam logic [3:0] CODE_LS   = 4'h6;
  localparam logic [3:0] CODE_RD   = 4'h4;
  localparam logic [3:0] CODE_TO   = 4'hC;
  localparam logic [3:0] CODE_TE   = 4'h2;
  localparam logic [3:0] CODE_MS   = 4'h0;
  localparam logic [3:0] IIR_TOP  = 4'hC;

  function automatic logic [3:0] code_of(sidx_t s);
    logic [3:0] c;
    case (s)
      SRC_LS:  c = CODE_LS;
      SRC_RD:  c = CODE_RD;
      SRC_TO:  c = CODE_TO;
      SRC_TE:  c = CODE_TE;
      SRC_MS:  c = CODE_MS;
      default: c = CODE_NONE;
    endcase
    return c;
  endfunction

  // Enable mask bits -> per-source enable, indexed by source
  function automatic logic [NSRC-1:0] en_map(logic [3:0] ier);
    logic [NSRC-1:0] e;
    e[SRC_LS] = ier[2];
    e[SRC_RD] = ier[0];
    e[SRC_TO] = ier[0];
    e[SRC_TE] = ier[1];
    e[SRC_MS] = ier[3];
    return e;
  endfunction

endpackage

// File: rtl/irq_id_pick.sv
module irq_id_pick #(
  parameter int unsigned N  = 5,
  parameter int unsigned IW = $clog2(N + 1)
) (
  input  logic [N-1:0]  req_i,
  output logic [IW-1:0] idx_o
);

  // Lowest set index wins; N means nothing requested
  always_comb begin
    idx_o = IW'(N);
    for (int i = int'(N) - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
  end

endmodule

// File: rtl/irq_id_pend.sv
module irq_id_pend #(
  parameter int unsigned N = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o,
  output logic [N-1:0] pend_nxt_o
);

  for (genvar g = 0; g < N; g++) begin : g_flag
    logic nxt;
    logic en;

    // A set in the same cycle as a clear keeps the flag
    always_comb begin
      nxt = set_i[g] | (pend_o[g] & ~clr_i[g]);
      en  = set_i[g] | clr_i[g];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  pend_o[g] <= 1'b0;
      else if (en)  pend_o[g] <= nxt;
    end

    assign pend_nxt_o[g] = en ? nxt : pend_o[g];
  end

endmodule

// File: rtl/irq_id_ctrl.sv
module irq_id_ctrl
  import irq_id_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ls_set_i,
  input  logic       rd_set_i,
  input  logic       to_set_i,
  input  logic       te_set_i,
  input  logic       ms_set_i,
  input  logic       ier_we_i,
  input  logic [7:0] ier_wdata_i,
  input  logic       iir_rd_i,
  input  logic       lsr_rd_i,
  input  logic       rbr_rd_i,
  input  logic       thr_wr_i,
  input  logic       msr_rd_i,
  output logic [7:0] iir_o,
  output logic       irq_o
);

  localparam int unsigned PAD_W = 1 << SIDX_W;

  logic [3:0]      ier_q, ier_nxt;
  sidx_t           shown_q, shown_nxt;
  logic            shown_en;
  logic [NSRC-1:0] set_v, clr_v, en_nxt;
  logic [NSRC-1:0] pend_q, pend_nxt;
  logic [PAD_W-1:0] gone_v;
  logic            shown_gone;
  sidx_t           best_all, best_new;

  always_comb begin
    set_v          = '0;
    set_v[SRC_LS]  = ls_set_i;
    set_v[SRC_RD]  = rd_set_i;
    set_v[SRC_TO]  = to_set_i;
    set_v[SRC_TE]  = te_set_i;
    set_v[SRC_MS]  = ms_set_i;

    clr_v          = '0;
    clr_v[SRC_LS]  = lsr_rd_i;
    clr_v[SRC_RD]  = rbr_rd_i;
    clr_v[SRC_TO]  = rbr_rd_i;
    clr_v[SRC_TE]  = thr_wr_i | (iir_rd_i && (shown_q == SRC_TE));
    clr_v[SRC_MS]  = msr_rd_i;

    ier_nxt = ier_we_i ? ier_wdata_i[3:0] : ier_q;
    en_nxt  = en_map(ier_nxt);
  end

  irq_id_pend #(.N(NSRC)) u_pend (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (set_v),
    .clr_i      (clr_v),
    .pend_o     (pend_q),
    .pend_nxt_o (pend_nxt)
  );

  irq_id_pick #(.N(NSRC), .IW(SIDX_W)) u_pick_all (
    .req_i (pend_nxt & en_nxt),
    .idx_o (best_all)
  );

  irq_id_pick #(.N(NSRC), .IW(SIDX_W)) u_pick_new (
    .req_i (set_v & en_nxt),
    .idx_o (best_new)
  );

  // Next-state: re-choose on enable write or loss of the shown source,
  // otherwise a new enabled event may only pre-empt downward in index
  always_comb begin
    gone_v     = PAD_W'(clr_v & ~set_v);
    shown_gone = gone_v[shown_q];
    shown_nxt  = shown_q;
    if (ier_we_i || shown_gone)   shown_nxt = best_all;
    else if (best_new <= shown_q) shown_nxt = best_new;
    shown_en = ier_we_i | shown_gone | (|set_v);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ier_q <= '0;
    else if (ier_we_i) ier_q <= ier_nxt;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       shown_q <= SRC_NONE;
    else if (shown_en) shown_q <= shown_nxt;
  end

  assign iir_o = {IIR_TOP, code_of(shown_q)};
  assign irq_o = (shown_q != SRC_NONE);

endmodule

// File: rtl/irq_id_chk.sv
module irq_id_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ls_set_i,
  input logic       rd_set_i,
  input logic       to_set_i,
  input logic       te_set_i,
  input logic       ms_set_i,
  input logic       ier_we_i,
  input logic [7:0] ier_wdata_i,
  input logic       iir_rd_i,
  input logic       lsr_rd_i,
  input logic       rbr_rd_i,
  input logic       thr_wr_i,
  input logic       msr_rd_i,
  input logic [7:0] iir_o,
  input logic       irq_o
);

  logic any_set, any_clr;
  assign any_set = ls_set_i | rd_set_i | to_set_i | te_set_i | ms_set_i;
  assign any_clr = iir_rd_i | lsr_rd_i | rbr_rd_i | thr_wr_i | msr_rd_i;

  // R2: byte always carries the fixed top nibble and a legal code
  always @(posedge clk_i) begin
    if (rst_ni) begin
      a_r2_legal_code: assert (iir_o[7:4] == 4'hC &&
        (iir_o[3:0] inside {4'h1, 4'h6, 4'h4, 4'hC, 4'h2, 4'h0}));
    end
  end

  // R4: an all-zero mask leaves nothing to report
  a_r4_zero_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ier_we_i && ier_wdata_i[3:0] == 4'h0 |=> !irq_o);

  // R6: request only rises after an event or an enable write
  a_r6_rise_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(any_set || ier_we_i));

  // R6: a lower event never displaces line status
  a_r6_lower_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iir_o[3:0] == 4'h6 && !lsr_rd_i && !ier_we_i |=> iir_o[3:0] == 4'h6);

  // R7: line-status read retires a shown line-status source
  a_r7_lsr_retires: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iir_o[3:0] == 4'h6 && lsr_rd_i && !ls_set_i && !ier_we_i |=> iir_o[3:0] != 4'h6);

  // R8: identification read retires a shown transmit-empty source
  a_r8_iir_rd_te: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iir_o[3:0] == 4'h2 && iir_rd_i && !te_set_i && !ier_we_i |=> iir_o[3:0] != 4'h2);

  // R10: retiring a non-shown modem source changes nothing visible
  a_r10_hidden_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msr_rd_i && iir_o[3:0] != 4'h0 && !any_set && !ier_we_i &&
    !(iir_rd_i | lsr_rd_i | rbr_rd_i | thr_wr_i) |=> $stable(iir_o));

  // R12: same-cycle set and retire of line status keeps it shown if it was
  a_r12_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ls_set_i && lsr_rd_i && iir_o[3:0] == 4'h6 && !ier_we_i |=> iir_o[3:0] == 4'h6);

  logic unused_clr;
  assign unused_clr = any_clr;

endmodule

bind irq_id_ctrl irq_id_chk u_irq_id_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ls_set_i    (ls_set_i),
  .rd_set_i    (rd_set_i),
  .to_set_i    (to_set_i),
  .te_set_i    (te_set_i),
  .ms_set_i    (ms_set_i),
  .ier_we_i    (ier_we_i),
  .ier_wdata_i (ier_wdata_i),
  .iir_rd_i    (iir_rd_i),
  .lsr_rd_i    (lsr_rd_i),
  .rbr_rd_i    (rbr_rd_i),
  .thr_wr_i    (thr_wr_i),
  .msr_rd_i    (msr_rd_i),
  .iir_o       (iir_o),
  .irq_o       (irq_o)
);

// File: tb/test_irq_id_ctrl.sv
`timescale 1ns/1ps
module test_irq_id_ctrl;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ls_set, rd_set, to_set, te_set, ms_set;
  logic       ier_we;
  logic [7:0] ier_wd;
  logic       iir_rd, lsr_rd, rbr_rd, thr_wr, msr_rd;
  logic [7:0] iir;
  logic       irq;

  int checks   = 0;
  int failures = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;

  irq_id_ctrl i_irq_id_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .ls_set_i(ls_set), .rd_set_i(rd_set), .to_set_i(to_set),
    .te_set_i(te_set), .ms_set_i(ms_set),
    .ier_we_i(ier_we), .ier_wdata_i(ier_wd),
    .iir_rd_i(iir_rd), .lsr_rd_i(lsr_rd), .rbr_rd_i(rbr_rd),
    .thr_wr_i(thr_wr), .msr_rd_i(msr_rd),
    .iir_o(iir), .irq_o(irq)
  );

  // Set mask bits: 0 ls, 1 rd, 2 to, 3 te, 4 ms
  // Strobe bits:   0 iir read, 1 lsr read, 2 rbr read, 3 thr write, 4 msr read
  task automatic step(input logic [4:0] s, input logic we, input logic [7:0] wd,
                      input logic [4:0] st, input logic [7:0] exp, input string tag);
    {ms_set, te_set, to_set, rd_set, ls_set} = s;
    ier_we = we; ier_wd = wd;
    {msr_rd, thr_wr, rbr_rd, lsr_rd, iir_rd} = st;
    @(posedge clk);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    {ms_set, te_set, to_set, rd_set, ls_set} = '0;
    ier_we = 1'b0; ier_wd = '0;
    {msr_rd, thr_wr, rbr_rd, lsr_rd, iir_rd} = '0;
  endtask

  // Monitor: compares the registered outputs one cycle after each step
  initial begin
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (iir !== e) begin
          failures++;
          $display("FAIL %s iir actual=%02h expected=%02h", t, iir, e);
        end
        checks++;
        if (irq !== (e[3:0] != 4'h1)) begin  // R11
          failures++;
          $display("FAIL %s/R11 irq actual=%0b expected=%0b", t, irq, e[3:0] != 4'h1);
        end
      end
    end
  end

  initial begin
    #(4 * 20000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    {ls_set, rd_set, to_set, te_set, ms_set} = '0;
    ier_we = 1'b0; ier_wd = '0;
    {iir_rd, lsr_rd, rbr_rd, thr_wr, msr_rd} = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step(5'b00000, 0, 8'h00, 5'b00000, 8'hC1, "R1 reset state");
    step(5'b11000, 0, 8'h00, 5'b00000, 8'hC1, "R1 mask zero after reset");
    step(5'b00000, 1, 8'hF0, 5'b00000, 8'hC1, "R4 upper mask bits ignored");
    step(5'b00000, 1, 8'h0A, 5'b00000, 8'hC2, "R5 enable write reveals te over ms R3");
    step(5'b00000, 0, 8'h00, 5'b00001, 8'hC0, "R8 R9 iir read retires shown te");
    step(5'b00000, 0, 8'h00, 5'b00001, 8'hC0, "R8 iir read with ms shown");
    step(5'b00000, 0, 8'h00, 5'b10000, 8'hC1, "R7 R9 msr read to none");
    step(5'b00000, 1, 8'h0F, 5'b00000, 8'hC1, "R5 enable all none pending");
    step(5'b00100, 0, 8'h00, 5'b00000, 8'hCC, "R2 timeout code");
    step(5'b00010, 0, 8'h00, 5'b00000, 8'hC4, "R6 data over timeout");
    step(5'b00001, 0, 8'h00, 5'b00000, 8'hC6, "R6 line status over data");
    step(5'b10000, 0, 8'h00, 5'b00000, 8'hC6, "R6 lower ms keeps ls");
    step(5'b00000, 0, 8'h00, 5'b00100, 8'hC6, "R10 rbr read of hidden sources");
    step(5'b00000, 0, 8'h00, 5'b00010, 8'hC0, "R9 R10 ls retired falls past dropped rd/to");
    step(5'b00000, 0, 8'h00, 5'b10000, 8'hC1, "R7 msr read retires ms");
    step(5'b01000, 0, 8'h00, 5'b00000, 8'hC2, "R2 te code");
    step(5'b00000, 0, 8'h00, 5'b01000, 8'hC1, "R7 thr write retires te");
    step(5'b00010, 0, 8'h00, 5'b00100, 8'hC4, "R12 set wins over rbr read");
    step(5'b00000, 0, 8'h00, 5'b00100, 8'hC1, "R7 rbr read retires rd");
    step(5'b00000, 1, 8'h0B, 5'b00000, 8'hC1, "R4 ls disabled");
    step(5'b00001, 0, 8'h00, 5'b00000, 8'hC1, "R5 disabled ls held pending");
    step(5'b00000, 1, 8'h0F, 5'b00000, 8'hC6, "R5 R4 enable write shows ls");
    step(5'b00000, 0, 8'h00, 5'b00010, 8'hC1, "R7 lsr read retires ls");
    step(5'b00010, 0, 8'h00, 5'b00000, 8'hC4, "R2 data code");
    step(5'b00000, 1, 8'h0E, 5'b00000, 8'hC1, "R5 disable shown rd");
    step(5'b00000, 1, 8'h0F, 5'b00000, 8'hC4, "R5 re-enable rd still pending");
    step(5'b00000, 0, 8'h00, 5'b00100, 8'hC1, "R7 rbr read clears rd");
    step(5'b01000, 0, 8'h00, 5'b00000, 8'hC2, "R6 te shown");
    step(5'b00001, 0, 8'h00, 5'b00000, 8'hC6, "R6 ls pre-empts te");
    step(5'b00000, 0, 8'h00, 5'b00001, 8'hC6, "R8 iir read with te hidden");
    step(5'b00000, 0, 8'h00, 5'b00010, 8'hC2, "R8 R9 te survived iir read");
    step(5'b00000, 0, 8'h00, 5'b01000, 8'hC1, "R7 thr write to none");
    step(5'b11111, 0, 8'h00, 5'b00000, 8'hC6, "R3 all at once ls first");
    step(5'b00000, 0, 8'h00, 5'b00010, 8'hC4, "R3 then rd");
    step(5'b00000, 0, 8'h00, 5'b00100, 8'hC2, "R3 rbr read drops rd and to then te");
    step(5'b00000, 0, 8'h00, 5'b01000, 8'hC0, "R3 then ms");
    step(5'b00000, 0, 8'h00, 5'b10000, 8'hC1, "R9 last retired");
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule